// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block carries out one complete NAND flash operation on an 8-bit flash bus, launched by a one-clock start pulse. The operation is described by two opcode bytes, a two-byte column address, a three-byte row address, a byte count and a 15-bit phase-enable word. Each bit of that word switches one phase on. The phases always run in the same hardware order: command, address bytes, outgoing data, second command, ready/busy wait, incoming data. Phases whose bit is clear are skipped. Every value is captured when the start pulse is accepted.

Data moves between the flash and a page buffer of 32-bit words. Bytes are packed big-endian, so the first byte on the bus sits in the top lane of word 0. The host loads the buffer before a program operation and reads it back after a read operation. The host can reach the buffer only while the sequencer is idle.

The controller is a five-state machine:
- `ST_IDLE`: waits for `start`. Transition *launch* goes to `ST_PICK`.
- `ST_PICK`: consumes the highest pending phase bit. Its transitions are:
  - *finish*: no bit is left; go to `ST_IDLE` and set `done`.
  - *wait*: the wait bit was taken; go to `ST_TWB`.
  - *skip*: an inert bit, or a data phase with a zero count; stay in `ST_PICK`.
  - *issue*: any other phase; go to `ST_BUS`.
- `ST_BUS`: runs bus cycles through the cycle engine. Transition *next byte* stays in `ST_BUS`. Transition *phase end* returns to `ST_PICK`.
- `ST_TWB`: ignores the ready/busy pin for a fixed allowance. Transition *allowance over* goes to `ST_RB`.
- `ST_RB`: waits for the synchronised ready level. Transition *ready* returns to `ST_PICK`.

Top module: `nfc_seq`

## Requirements
- R1: Phase-enable bits are: 14 first command, 13 and 12 column bytes 0 and 1, 11, 10 and 9 row bytes 0, 1 and 2, 8 outgoing data, 7 second command, 6 ready/busy wait, 5 incoming data. Enabled phases run from bit 14 down to bit 5. Clear bits produce no bus cycle.
- R2: An address phase drives one cycle with `nf_ale` high. Column byte k is `col_addr[8k+7:8k]`, and row byte k is `row_addr[8k+7:8k]`. Byte 0 goes out before byte 1.
- R3: Bit 14 drives `op_first` and bit 7 drives `op_second`, each as one cycle with `nf_cle` high.
- R4: A write cycle holds `nf_we_n` low for exactly 2 clocks, then high for at least 2 clocks. `nf_dq_o`, `nf_cle`, `nf_ale` and `nf_dq_oe`=1 stay valid across the rising edge. `nf_we_n` and `nf_re_n` are never low together, and `nf_cle` and `nf_ale` are never high together.
- R5: A read cycle holds `nf_re_n` low for exactly 2 clocks and captures `nf_dq_i` on its rising edge. `nf_dq_oe` is 0 while `nf_re_n` is low.
- R6: Byte n of a data phase maps to buffer word n/4, bits 31-8(n%4) down to 24-8(n%4). Incoming data changes only the lanes it covers.
- R7: A data phase moves `xfer_len` bytes. A count of 0 moves none. A count above 4*BUF_WORDS is clamped to 4*BUF_WORDS.
- R8: The wait phase drives no bus cycle. It ignores `nf_rb` for 4 clocks, then waits until the `nf_rb` level, seen through two synchroniser flops, is high.
- R9: `busy` is high from an accepted start to the end of the operation. A start while busy is ignored. `done` rises when the last phase ends and clears on the next accepted start.
- R10: While idle, `host_we` writes a word. `host_rdata` shows the addressed word one clock later. Host writes while busy are ignored.
- R11: Bits 4 to 0 of `code` cause no bus cycle.
- R12: Code 0x4040 issues one command cycle and then waits for ready. Code 0x4068 issues one command cycle, waits for ready, then reads `xfer_len` bytes into the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch pulse |
| code | input | 15 | Phase-enable word |
| op_first | input | 8 | First command opcode |
| op_second | input | 8 | Second command opcode |
| col_addr | input | 16 | Column address bytes |
| row_addr | input | 24 | Row address bytes |
| xfer_len | input | LEN_W | Data phase byte count |
| busy | output | 1 | Operation running |
| done | output | 1 | Operation finished |
| host_we | input | 1 | Buffer word write |
| host_addr | input | AW | Buffer word address |
| host_wdata | input | 32 | Buffer write word |
| host_rdata | output | 32 | Buffer read word, one clock latency |
| nf_cle | output | 1 | Flash command latch enable |
| nf_ale | output | 1 | Flash address latch enable |
| nf_we_n | output | 1 | Flash write strobe, active low |
| nf_re_n | output | 1 | Flash read strobe, active low |
| nf_dq_o | output | 8 | Flash bus out |
| nf_dq_oe | output | 1 | Flash bus drive enable |
| nf_dq_i | input | 8 | Flash bus in |
| nf_rb | input | 1 | Flash ready (high) / busy (low) |

## Verification
The bench builds the block with BUF_WORDS=4, a 16-byte buffer, and leaves LEN_W=16 and TWB_CLKS=4 at their defaults. The small buffer puts the clamp of a too-large byte count, and the packing of the final word, within a single short operation. The wide count field still lets the bench ask for 20 bytes and see the clamp to 16.

// File: rtl/nfc_seq_pkg.sv
package nfc_seq_pkg;
    localparam int CODE_W = 15;

    // Phase bit positions: the order is the behaviour, highest runs first
    localparam logic [3:0] B_CMD1  = 4'd14;
    localparam logic [3:0] B_COL0  = 4'd13;
    localparam logic [3:0] B_COL1  = 4'd12;
    localparam logic [3:0] B_ROW0  = 4'd11;
    localparam logic [3:0] B_ROW1  = 4'd10;
    localparam logic [3:0] B_ROW2  = 4'd9;
    localparam logic [3:0] B_WDATA = 4'd8;
    localparam logic [3:0] B_CMD2  = 4'd7;
    localparam logic [3:0] B_WAIT  = 4'd6;
    localparam logic [3:0] B_RDATA = 4'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_BUS,
        ST_TWB,
        ST_RB
    } seq_state_t;
endpackage

// File: rtl/nfc_bus_cycle.sv
module nfc_bus_cycle (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       is_rd,
    input  logic       cle_in,
    input  logic       ale_in,
    input  logic [7:0] wbyte,
    input  logic [7:0] dq_i,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] dq_o,
    output logic       dq_oe,
    output logic [7:0] rbyte,
    output logic       cyc_done
);
    // Four-clock cycle: strobe low in steps 0-1, high in steps 2-3
    logic [1:0] step_q;
    logic       active_q;

    assign cyc_done = active_q && (step_q == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= '0;
            active_q <= 1'b0;
            we_n     <= 1'b1;
            re_n     <= 1'b1;
            cle      <= 1'b0;
            ale      <= 1'b0;
            dq_o     <= '0;
            dq_oe    <= 1'b0;
            rbyte    <= '0;
        end else if (go && !active_q) begin
            active_q <= 1'b1;
            step_q   <= '0;
            we_n     <= is_rd;
            re_n     <= !is_rd;
            cle      <= cle_in && !is_rd;
            ale      <= ale_in && !is_rd;
            dq_o     <= is_rd ? 8'h00 : wbyte;
            dq_oe    <= !is_rd;
        end else if (active_q) begin
            step_q <= step_q + 2'd1;
            if (step_q == 2'd1) begin
                we_n <= 1'b1;
                re_n <= 1'b1;
                if (!re_n) rbyte <= dq_i;
            end
            if (step_q == 2'd3) begin
                active_q <= 1'b0;
                cle      <= 1'b0;
                ale      <= 1'b0;
                dq_oe    <= 1'b0;
            end
        end
    end

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);
    a_r4_write_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !active_q && !is_rd) |=> (!we_n && dq_oe));
endmodule

// File: rtl/nfc_page_buf.sv
module nfc_page_buf #(
    parameter int WORDS = 528,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    input  logic [AW-1:0] eng_word,
    input  logic [1:0]    eng_lane,
    input  logic          eng_we,
    input  logic [7:0]    eng_wbyte,
    output logic [7:0]    eng_rbyte
);
    logic [31:0] mem [WORDS];
    logic [31:0] eng_w;

    assign eng_w = mem[eng_word];

    // Big-endian lanes: lane 0 is bits 31:24
    always_comb begin
        unique case (eng_lane)
            2'd0: eng_rbyte = eng_w[31:24];
            2'd1: eng_rbyte = eng_w[23:16];
            2'd2: eng_rbyte = eng_w[15:8];
            default: eng_rbyte = eng_w[7:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (host_we) begin
            mem[host_addr] <= host_wdata;
        end else if (eng_we) begin
            mem[eng_word][8*(3-eng_lane) +: 8] <= eng_wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_rdata <= '0;
        else        host_rdata <= mem[host_addr];
    end

    a_r10_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && eng_we));
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_seq_pkg::*;
#(
    parameter int BUF_WORDS = 528,
    parameter int LEN_W     = 16,
    parameter int TWB_CLKS  = 4,
    localparam int AW       = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [14:0]       code,
    input  logic [7:0]        op_first,
    input  logic [7:0]        op_second,
    input  logic [15:0]       col_addr,
    input  logic [23:0]       row_addr,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              busy,
    output logic              done,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [7:0]        nf_dq_o,
    output logic              nf_dq_oe,
    input  logic [7:0]        nf_dq_i,
    input  logic              nf_rb
);
    localparam int BYTES = BUF_WORDS * 4;
    localparam int CNT_W = $clog2(BYTES + 1);
    localparam int TW    = (TWB_CLKS > 1) ? $clog2(TWB_CLKS) : 1;
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(BYTES);

    seq_state_t state_q, state_d;

    logic [CODE_W-1:0] pend_q;
    logic [7:0]        op1_q, op2_q;
    logic [15:0]       col_q;
    logic [23:0]       row_q;
    logic [CNT_W-1:0]  len_q, bc_q;
    logic [3:0]        cur_ph_q;
    logic              issued_q, done_q;
    logic [TW-1:0]     twb_q;
    logic              rb_s1, rb_s2;

    logic              found;
    logic [3:0]        pick;
    logic              is_data, last_byte;
    logic              go, is_rd, cle_c, ale_c, eng_we;
    logic [7:0]        wbyte, rbyte, eng_rbyte;
    logic              cyc_done;
    logic [CNT_W-1:0]  len_eff;

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    assign len_eff   = (xfer_len > MAX_LEN) ? CNT_W'(BYTES) : xfer_len[CNT_W-1:0];
    assign is_data   = (cur_ph_q == B_WDATA) || (cur_ph_q == B_RDATA);
    assign last_byte = ((bc_q + CNT_W'(1)) == len_q);

    // Highest pending bit wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (pend_q[i]) begin
                found = 1'b1;
                pick  = 4'(i);
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PICK;
            ST_PICK: begin
                if (!found)
                    state_d = ST_IDLE;
                else if (pick == B_WAIT)
                    state_d = ST_TWB;
                else if (pick < B_RDATA)
                    state_d = ST_PICK;
                else if (((pick == B_WDATA) || (pick == B_RDATA)) && (len_q == '0))
                    state_d = ST_PICK;
                else
                    state_d = ST_BUS;
            end
            ST_BUS: if (cyc_done && !(is_data && !last_byte)) state_d = ST_PICK;
            ST_TWB: if (twb_q == TW'(TWB_CLKS - 1)) state_d = ST_RB;
            ST_RB:  if (rb_s2) state_d = ST_PICK;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            op1_q    <= '0;
            op2_q    <= '0;
            col_q    <= '0;
            row_q    <= '0;
            len_q    <= '0;
            bc_q     <= '0;
            cur_ph_q <= '0;
            issued_q <= 1'b0;
            done_q   <= 1'b0;
            twb_q    <= '0;
            rb_s1    <= 1'b0;
            rb_s2    <= 1'b0;
        end else begin
            rb_s1 <= nf_rb;
            rb_s2 <= rb_s1;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pend_q <= code;
                        op1_q  <= op_first;
                        op2_q  <= op_second;
                        col_q  <= col_addr;
                        row_q  <= row_addr;
                        len_q  <= len_eff;
                        done_q <= 1'b0;
                    end
                end
                ST_PICK: begin
                    if (found) begin
                        pend_q[pick] <= 1'b0;
                        cur_ph_q     <= pick;
                        bc_q         <= '0;
                        issued_q     <= 1'b0;
                        twb_q        <= '0;
                    end else begin
                        done_q <= 1'b1;
                    end
                end
                ST_BUS: begin
                    if (go) issued_q <= 1'b1;
                    if (cyc_done) begin
                        issued_q <= 1'b0;
                        if (is_data && !last_byte) bc_q <= bc_q + CNT_W'(1);
                    end
                end
                ST_TWB: twb_q <= twb_q + TW'(1);
                default: begin end
            endcase
        end
    end

    // Outputs to the cycle engine and buffer
    always_comb begin
        go     = (state_q == ST_BUS) && !issued_q;
        is_rd  = (cur_ph_q == B_RDATA);
        cle_c  = (cur_ph_q == B_CMD1) || (cur_ph_q == B_CMD2);
        ale_c  = (cur_ph_q <= B_COL0) && (cur_ph_q >= B_ROW2);
        eng_we = (state_q == ST_BUS) && cyc_done && is_rd;
        unique case (cur_ph_q)
            B_CMD1:  wbyte = op1_q;
            B_CMD2:  wbyte = op2_q;
            B_COL0:  wbyte = col_q[7:0];
            B_COL1:  wbyte = col_q[15:8];
            B_ROW0:  wbyte = row_q[7:0];
            B_ROW1:  wbyte = row_q[15:8];
            B_ROW2:  wbyte = row_q[23:16];
            default: wbyte = eng_rbyte;
        endcase
    end

    nfc_bus_cycle u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .is_rd    (is_rd),
        .cle_in   (cle_c),
        .ale_in   (ale_c),
        .wbyte    (wbyte),
        .dq_i     (nf_dq_i),
        .we_n     (nf_we_n),
        .re_n     (nf_re_n),
        .cle      (nf_cle),
        .ale      (nf_ale),
        .dq_o     (nf_dq_o),
        .dq_oe    (nf_dq_oe),
        .rbyte    (rbyte),
        .cyc_done (cyc_done)
    );

    nfc_page_buf #(.WORDS(BUF_WORDS)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we && !busy),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_word   (bc_q[AW+1:2]),
        .eng_lane   (bc_q[1:0]),
        .eng_we     (eng_we),
        .eng_wbyte  (rbyte),
        .eng_rbyte  (eng_rbyte)
    );

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(len_q) && $stable(op1_q) && $stable(col_q)));
    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RB && !rb_s2) |=> (state_q == ST_RB));
    a_r8_no_bus_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TWB || state_q == ST_RB) |-> (nf_we_n && nf_re_n));
    a_r9_done_rises_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);
endmodule

// File: tb/nfc_seq_bench.sv
`timescale 1ns/1ps
module nfc_seq_bench;
    localparam int BW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] code = '0;
    logic [7:0]  op_first = '0, op_second = '0;
    logic [15:0] col_addr = '0;
    logic [23:0] row_addr = '0;
    logic [15:0] xfer_len = '0;
    logic        busy, done;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_o, nf_dq_i;
    logic        nf_rb = 1'b1;

    always #2 clk = ~clk;

    // Flash read model: byte at offset (reads so far - base)
    logic [7:0] rd_bytes [32];
    int         rd_cnt = 0;
    int         rd_base = 0;
    assign nf_dq_i = rd_bytes[5'(rd_cnt - rd_base)];

    nfc_seq #(.BUF_WORDS(BW)) u_nfc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .code(code),
        .op_first(op_first), .op_second(op_second),
        .col_addr(col_addr), .row_addr(row_addr), .xfer_len(xfer_len),
        .busy(busy), .done(done),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
    );

    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;

    // Scoreboard of expected write cycles: {cle, ale, byte}
    logic [9:0] exp_q [$];

    task automatic push_ev(input logic c, input logic a, input logic [7:0] b);
        exp_q.push_back({c, a, b});
    endtask

    task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Monitor: pops and compares on every strobe rising edge
    int   we_low = 0, re_low = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nf_re_n && nf_dq_oe) begin
                m_chk++; m_fail++;
                $display("FAIL R5 bus driven during read actual=1 expected=0");
            end
            if (!nf_we_n) we_low++;
            if (!nf_re_n) re_low++;
            if (!prev_we && nf_we_n) begin
                m_chk++;
                if (exp_q.size() == 0) begin
                    m_fail++;
                    $display("FAIL R1 unexpected cycle actual=%h expected=none", {nf_cle, nf_ale, nf_dq_o});
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    if ({nf_cle, nf_ale, nf_dq_o} != e || !nf_dq_oe || we_low != 2) begin
                        m_fail++;
                        $display("FAIL R4 cycle actual=%h/oe%0d/low%0d expected=%h/oe1/low2",
                                 {nf_cle, nf_ale, nf_dq_o}, nf_dq_oe, we_low, e);
                    end
                end
                we_low = 0;
            end
            if (!prev_re && nf_re_n) begin
                m_chk++;
                if (re_low != 2) begin
                    m_fail++;
                    $display("FAIL R5 read low width actual=%0d expected=2", re_low);
                end
                rd_cnt++;
                re_low = 0;
            end
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    task automatic start_op(input logic [14:0] c, input logic [7:0] o1, input logic [7:0] o2,
                            input logic [15:0] ca, input logic [23:0] ra, input logic [15:0] ln);
        code = c; op_first = o1; op_second = o2;
        col_addr = ca; row_addr = ra; xfer_len = ln;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string rq, output int cyc);
        cyc = 0;
        while (!(done && !busy) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done && !busy, rq, {30'd0, done, busy}, 32'h2);
        chk(exp_q.size() == 0, rq, exp_q.size(), 0);
    endtask

    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [31:0] d);
        host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk + m_chk + 1, n_fail + m_fail + 1);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] w;
        for (int i = 0; i < 32; i++) rd_bytes[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9/R4 reset state
        chk(!busy && !done, "R9 reset flags", {30'd0, busy, done}, 0);
        chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale, "R4 reset pins",
            {28'd0, nf_we_n, nf_re_n, nf_cle, nf_ale}, 32'hC);

        // R1 R2 R3 R6: full program sequence
        hw(2'd0, 32'hA1B2C3D4);
        hw(2'd1, 32'h55667788);
        hw(2'd3, 32'h01020304);
        push_ev(1, 0, 8'h80);
        push_ev(0, 1, 8'h34); push_ev(0, 1, 8'h12);
        push_ev(0, 1, 8'h9A); push_ev(0, 1, 8'h78); push_ev(0, 1, 8'h56);
        push_ev(0, 0, 8'hA1); push_ev(0, 0, 8'hB2); push_ev(0, 0, 8'hC3);
        push_ev(0, 0, 8'hD4); push_ev(0, 0, 8'h55); push_ev(0, 0, 8'h66);
        push_ev(1, 0, 8'h10);
        start_op(15'h7FC0, 8'h80, 8'h10, 16'h1234, 24'h56789A, 16'd6);
        chk(busy, "R9 busy after start", {31'd0, busy}, 1);
        wait_done("R1 program sequence", cyc);

        // R5 R6: read sequence packs bytes big-endian
        hw(2'd0, 32'h0);
        hw(2'd1, 32'hFFFFFFFF);
        for (int i = 0; i < 5; i++) rd_bytes[i] = 8'(8'h11 + i);
        rd_base = rd_cnt;
        push_ev(1, 0, 8'h00);
        push_ev(0, 1, 8'h40); push_ev(0, 1, 8'h00);
        push_ev(0, 1, 8'h02); push_ev(0, 1, 8'h01);
        push_ev(1, 0, 8'h30);
        start_op(15'h7CE0, 8'h00, 8'h30, 16'h0040, 24'h000102, 16'd5);
        wait_done("R5 read sequence", cyc);
        chk(rd_cnt - rd_base == 5, "R5 read count", rd_cnt - rd_base, 5);
        hr(2'd0, w);
        chk(w == 32'h11121314, "R6 packed word0", w, 32'h11121314);
        hr(2'd1, w);
        chk(w == 32'h15FFFFFF, "R6 partial word1", w, 32'h15FFFFFF);

        // R12 status read 0x4068
        rd_bytes[0] = 8'hE0;
        rd_base = rd_cnt;
        push_ev(1, 0, 8'h70);
        start_op(15'h4068, 8'h70, 8'h00, 16'h0, 24'h0, 16'd1);
        wait_done("R12 status read", cyc);
        hr(2'd0, w);
        chk(w == 32'hE0121314, "R12 status byte", w, 32'hE0121314);

        // R8 R9 R10 R12: reset op waits on busy pin
        nf_rb = 1'b0;
        push_ev(1, 0, 8'hFF);
        start_op(15'h4040, 8'hFF, 8'h00, 16'h0, 24'h0, 16'd0);
        repeat (40) @(negedge clk);
        chk(busy && !done, "R8 holds while flash busy", {30'd0, busy, done}, 2);
        start_op(15'h4000, 8'h55, 8'h00, 16'h0, 24'h0, 16'd0);
        hw(2'd3, 32'hDEADBEEF);
        repeat (10) @(negedge clk);
        chk(busy, "R9 start while busy ignored", {31'd0, busy}, 1);
        nf_rb = 1'b1;
        wait_done("R8 release on ready", cyc);
        chk(cyc <= 8, "R8 ready latency", cyc, 8);
        hr(2'd3, w);
        chk(w == 32'h01020304, "R10 busy write ignored", w, 32'h01020304);

        // R1 R2 skip: row byte 0 and second command only
        push_ev(0, 1, 8'hC7);
        push_ev(1, 0, 8'hD0);
        start_op(15'h0880, 8'h11, 8'hD0, 16'hAAAA, 24'h3344C7, 16'd0);
        chk(!done, "R9 done cleared by start", {31'd0, done}, 0);
        wait_done("R1 skipped phases", cyc);

        // R11 low bits inert
        start_op(15'h001F, 8'h11, 8'h22, 16'h0, 24'h0, 16'd4);
        wait_done("R11 low bits no cycles", cyc);

        // R7 zero count moves no data
        push_ev(1, 0, 8'h85);
        start_op(15'h4100, 8'h85, 8'h00, 16'h0, 24'h0, 16'd0);
        wait_done("R7 zero count", cyc);

        // R7 clamp to buffer size
        for (int i = 0; i < BW; i++)
            hw(2'(i), {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
        for (int i = 0; i < 4*BW; i++) push_ev(0, 0, 8'(i));
        start_op(15'h0100, 8'h00, 8'h00, 16'h0, 24'h0, 16'd20);
        wait_done("R7 clamp", cyc);

        // R10 idle write then read with one clock latency
        hw(2'd2, 32'hCAFEF00D);
        hr(2'd2, w);
        chk(w == 32'hCAFEF00D, "R10 host access", w, 32'hCAFEF00D);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk + m_chk, n_fail + m_fail);
        $finish;
    end
endmodule